// File: doc/BRIEF.md
# Page-Mode Asynchronous DRAM Device Model

This block behaves like the device side of a small asynchronous dynamic memory so that a memory controller can be exercised against it in synthesizable form. The controller drives a shared row/column address bus and four active-low strobes (row strobe, column strobe, write enable, output enable). A fast internal clock samples these strobes. From the order of their edges the model decides whether a cycle is a data access or one of three refresh types. Data lives in a register array indexed by row and column, with one word of `DATA_W` bits per column.

A falling row strobe with the column strobe high opens a row at the address on the bus. Each later falling column strobe latches a column and either writes that word or reads it. Holding the row strobe low gives a page-mode burst. The output can run in fast-page style or in extended-data-out style, chosen by a parameter. Refresh cycles are reported on a one-cycle pulse that gives the refresh type and the row. A per-row age counter raises a sticky error if any row goes unrefreshed for longer than a parameterised number of clocks.

Top module: `pagemode_dram_model`

## Requirements
- R1: After reset `dq_oe`, `ref_valid` and `refresh_err` are 0, and the internal refresh row counter is 0, so the first counter refresh reports row 0.
- R2: The row is captured on the clock that first samples `ras_n` low while `cas_n` is high. The column is captured on the clock that first samples `cas_n` low while that row is open. With `we_n` low, `dq_in` is stored at [row][column]. With `we_n` high, the stored word appears on `dq_out` after that same clock edge.
- R3: While `ras_n` stays low, each new falling `cas_n` addresses a new column of the already open row, and no new row address is needed.
- R4: A write changes only the addressed word. Other columns of the same row and the same column of other rows keep their contents.
- R5: With `EDO_MODE`=0, `dq_oe` is 1 only while `oe_n` and `cas_n` are both low after a read. Read data is dropped when `cas_n` rises. Whenever `dq_oe` is 0, `dq_out` is 0.
- R6: With `EDO_MODE`=1, read data stays driven after `cas_n` rises, for as long as `oe_n` is low. A new read replaces it. It is dropped when `oe_n` rises.
- R7: A row opened and then closed with no falling `cas_n` in between is a RAS-only refresh. At the `ras_n` rise it gives one `ref_valid` cycle with `ref_kind`=0 and `ref_row` equal to the latched row, and the counter is unchanged. A cycle that did access a column gives no pulse when it closes.
- R8: A falling `ras_n` while `cas_n` is already low, with no read left pending, is a CAS-before-RAS refresh. It gives `ref_kind`=1, and `ref_row` equals the counter, which then increments modulo 2^ROW_W.
- R9: If `cas_n` stays low after a read, `ras_n` rises and then falls again, this is a hidden refresh. It gives `ref_kind`=2 with `ref_row` from the counter, and the read data stays on `dq_out` during that cycle.
- R10: Every row activation or refresh clears that row's age counter. `refresh_err` goes to 1 once any row's age reaches `REFRESH_LIMIT` clocks, and it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low, sampled at the column strobe |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data, 0 when not driven |
| dq_oe | output | 1 | Data pins driven |
| ref_valid | output | 1 | One-cycle refresh report |
| ref_kind | output | 2 | 0 RAS-only, 1 CAS-before-RAS, 2 hidden |
| ref_row | output | ROW_W | Row refreshed |
| refresh_err | output | 1 | Sticky refresh-age violation |

## Verification
A hidden refresh and a pending read can fall on the same clock: the refresh report comes up while the earlier read word must still be on the data pins. The bench provokes this with a page read, then takes the row strobe high and low again while keeping the column and output strobes low. On the clock after the second fall it requires `ref_valid` with the hidden type and the counter's row, and it also requires the old read word on `dq_out`, with `dq_oe` still high. A fast-page instance and an extended-data-out instance run the same stimulus, so the two release rules for read data are judged against each other on every vector.

// File: rtl/pagemode_dram_model.sv
module pagemode_dram_model #(
  parameter int ROW_W         = 4,
  parameter int COL_W         = 4,
  parameter int ADDR_W        = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int DATA_W        = 4,
  parameter bit EDO_MODE      = 1'b0,
  parameter int REFRESH_LIMIT = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              ref_valid,
  output logic [1:0]        ref_kind,
  output logic [ROW_W-1:0]  ref_row,
  output logic              refresh_err
);

  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;
  localparam int AGE_W = $clog2(REFRESH_LIMIT + 1);
  localparam logic [1:0] K_RASONLY = 2'd0;
  localparam logic [1:0] K_CBR     = 2'd1;
  localparam logic [1:0] K_HIDDEN  = 2'd2;

  logic ras_q, cas_q, oe_q;
  logic row_open, cas_seen, cas_held, data_valid;
  logic [ROW_W-1:0]  row_reg, ref_cnt;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] mem [ROWS][COLS];
  logic [AGE_W-1:0]  age [ROWS];

  logic ras_fall, ras_rise, cas_fall, cas_rise, oe_rise;
  logic access, do_wr, do_rd, cnt_ref, open_row, ras_only;
  logic rf_hit, any_stale;
  logic [ROW_W-1:0] arow, rf_idx;
  logic [COL_W-1:0] col;

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign cas_rise = ~cas_q & cas_n;
  assign oe_rise  = ~oe_q & oe_n;

  assign arow     = addr[ROW_W-1:0];
  assign col      = addr[COL_W-1:0];
  assign access   = cas_fall & row_open & ~ras_n;
  assign do_wr    = access & ~we_n;
  assign do_rd    = access & we_n;
  assign open_row = ras_fall & cas_n;
  assign cnt_ref  = ras_fall & ~cas_n;
  assign ras_only = ras_rise & row_open & ~cas_seen;
  assign rf_hit   = open_row | cnt_ref;
  assign rf_idx   = cnt_ref ? ref_cnt : arow;

  assign dq_oe  = data_valid & ~oe_n & (EDO_MODE | ~cas_n);
  assign dq_out = dq_oe ? rd_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q      <= 1'b1;
      cas_q      <= 1'b1;
      oe_q       <= 1'b1;
      row_open   <= 1'b0;
      cas_seen   <= 1'b0;
      cas_held   <= 1'b0;
      data_valid <= 1'b0;
      row_reg    <= '0;
      ref_cnt    <= '0;
      rd_q       <= '0;
      ref_valid  <= 1'b0;
      ref_kind   <= K_RASONLY;
      ref_row    <= '0;
    end else begin
      ras_q     <= ras_n;
      cas_q     <= cas_n;
      oe_q      <= oe_n;
      ref_valid <= 1'b0;

      if (open_row) begin
        row_open <= 1'b1;
        row_reg  <= arow;
        cas_seen <= 1'b0;
      end else if (ras_rise) begin
        row_open <= 1'b0;
      end
      if (access) cas_seen <= 1'b1;

      if (access)        cas_held <= we_n;
      else if (cas_rise) cas_held <= 1'b0;

      if (cnt_ref) begin
        ref_valid <= 1'b1;
        ref_row   <= ref_cnt;
        ref_kind  <= cas_held ? K_HIDDEN : K_CBR;
        ref_cnt   <= ref_cnt + 1'b1;
      end else if (ras_only) begin
        ref_valid <= 1'b1;
        ref_row   <= row_reg;
        ref_kind  <= K_RASONLY;
      end

      if (do_rd) begin
        data_valid <= 1'b1;
        rd_q       <= mem[row_reg][col];
      end else if (do_wr) begin
        data_valid <= 1'b0;
      end else if (EDO_MODE ? oe_rise : cas_rise) begin
        data_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[row_reg][col] <= dq_in;
  end

  always_comb begin
    any_stale = 1'b0;
    for (int r = 0; r < ROWS; r++)
      if (age[r] == AGE_W'(REFRESH_LIMIT)) any_stale = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) age[r] <= '0;
      refresh_err <= 1'b0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (rf_hit && rf_idx == ROW_W'(r))
          age[r] <= '0;
        else if (age[r] != AGE_W'(REFRESH_LIMIT))
          age[r] <= age[r] + AGE_W'(1);
      end
      if (any_stale) refresh_err <= 1'b1;
    end
  end

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (row_open && !ras_n && !$past(ras_n) && !$past(ras_n, 2)) |-> $stable(row_reg)); // R3
  AST_REF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> !ref_valid); // R7
  AST_CNT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_kind != K_RASONLY) |-> ref_row == ROW_W'(ref_cnt - 1'b1)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_err |=> refresh_err); // R10

endmodule

// File: tb/sim_pagemode_dram_model.sv
module sim_pagemode_dram_model;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0] addr = '0, dq_in = '0;
  logic [3:0] d0, d1, rrow0, rrow1;
  logic oe0, oe1, rv0, rv1, err0, err1;
  logic [1:0] rk0, rk1;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pagemode_dram_model #(.ROW_W(4), .COL_W(4), .DATA_W(4), .EDO_MODE(1'b0), .REFRESH_LIMIT(200)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(d0), .dq_oe(oe0), .ref_valid(rv0),
    .ref_kind(rk0), .ref_row(rrow0), .refresh_err(err0));

  pagemode_dram_model #(.ROW_W(4), .COL_W(4), .DATA_W(4), .EDO_MODE(1'b1), .REFRESH_LIMIT(200)) u1 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(d1), .dq_oe(oe1), .ref_valid(rv1),
    .ref_kind(rk1), .ref_row(rrow1), .refresh_err(err1));

  typedef struct packed {
    logic ras, cas, we, oe;
    logic [3:0] a, d;
    logic chk, e0oe;
    logic [3:0] e0d;
    logic e1oe;
    logic [3:0] e1d;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1,1,1,1, 4'h0, 4'h0, 1, 0, 4'h0, 0, 4'h0}, // idle, R5
    '{0,1,1,1, 4'h3, 4'h0, 1, 0, 4'h0, 0, 4'h0}, // open row 3, R2
    '{0,0,0,1, 4'h5, 4'hA, 1, 0, 4'h0, 0, 4'h0}, // write [3][5]=A, R2
    '{0,1,1,1, 4'h5, 4'h0, 0, 0, 4'h0, 0, 4'h0},
    '{0,0,0,1, 4'h6, 4'h5, 1, 0, 4'h0, 0, 4'h0}, // page write [3][6]=5, R3
    '{0,1,1,1, 4'h6, 4'h0, 0, 0, 4'h0, 0, 4'h0},
    '{1,1,1,1, 4'h0, 4'h0, 0, 0, 4'h0, 0, 4'h0},
    '{0,1,1,1, 4'h4, 4'h0, 0, 0, 4'h0, 0, 4'h0}, // open row 4
    '{0,0,0,1, 4'h5, 4'hC, 0, 0, 4'h0, 0, 4'h0}, // write [4][5]=C, R4
    '{0,1,1,1, 4'h5, 4'h0, 0, 0, 4'h0, 0, 4'h0},
    '{1,1,1,1, 4'h0, 4'h0, 0, 0, 4'h0, 0, 4'h0},
    '{0,1,1,1, 4'h3, 4'h0, 0, 0, 4'h0, 0, 4'h0}, // open row 3
    '{0,0,1,0, 4'h5, 4'h0, 1, 1, 4'hA, 1, 4'hA}, // read [3][5], R2
    '{0,1,1,0, 4'h6, 4'h0, 1, 0, 4'h0, 1, 4'hA}, // CAS up: R5 drop, R6 hold
    '{0,0,1,0, 4'h6, 4'h0, 1, 1, 4'h5, 1, 4'h5}, // page read [3][6], R3 R6
    '{0,0,1,1, 4'h6, 4'h0, 1, 0, 4'h0, 0, 4'h0}, // OE high, R5
    '{0,1,1,0, 4'h6, 4'h0, 1, 0, 4'h0, 0, 4'h0}, // EDO released by OE rise, R6
    '{0,0,1,0, 4'h5, 4'h0, 1, 1, 4'hA, 1, 4'hA}, // [3][5] untouched, R4
    '{0,1,1,0, 4'h5, 4'h0, 1, 0, 4'h0, 1, 4'hA}, // R6
    '{1,1,1,0, 4'h0, 4'h0, 1, 0, 4'h0, 1, 4'hA}, // RAS up, R6
    '{1,1,1,1, 4'h0, 4'h0, 1, 0, 4'h0, 0, 4'h0}  // R6
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic c, input logic w, input logic o,
                      input logic [3:0] a, input logic [3:0] d);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; dq_in = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int exp_cnt;
    do_reset();
    // R1 reset state
    check(oe0 == 0 && oe1 == 0, "R1", "dq_oe", {oe0, oe1}, 0);
    check(rv0 == 0, "R1", "ref_valid", rv0, 0);
    check(err0 == 0 && err1 == 0, "R1", "refresh_err", {err0, err1}, 0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].ras, TBL[i].cas, TBL[i].we, TBL[i].oe, TBL[i].a, TBL[i].d);
      if (TBL[i].chk) begin
        check(oe0 == TBL[i].e0oe && d0 == TBL[i].e0d, "R2-R5 fast-page vector",
              $sformatf("u0 vec %0d", i), {oe0, d0}, {TBL[i].e0oe, TBL[i].e0d});
        check(oe1 == TBL[i].e1oe && d1 == TBL[i].e1d, "R6 edo vector",
              $sformatf("u1 vec %0d", i), {oe1, d1}, {TBL[i].e1oe, TBL[i].e1d});
      end
    end

    // R9 hidden refresh while read data is held
    step(0,1,1,1, 4'h3, 0);
    step(0,0,1,0, 4'h5, 0);
    check(oe0 && d0 == 4'hA, "R9", "read before hidden", d0, 4'hA);
    step(1,0,1,0, 4'h0, 0);
    check(rv0 == 0, "R7", "no pulse after accessed cycle", rv0, 0);
    check(oe0 && d0 == 4'hA, "R9", "data held with RAS high", d0, 4'hA);
    step(0,0,1,0, 4'h0, 0);
    check(rv0 == 1 && rk0 == 2'd2 && rrow0 == 4'd0, "R9", "hidden report",
          {rv0, rk0, rrow0}, {1'b1, 2'd2, 4'd0});
    check(oe0 == 1 && d0 == 4'hA, "R9", "data during hidden refresh", {oe0, d0}, {1'b1, 4'hA});
    step(1,0,1,0, 4'h0, 0);
    check(rv0 == 0, "R9", "pulse one cycle", rv0, 0);
    step(1,1,1,1, 4'h0, 0);

    // R7 RAS-only
    step(0,1,1,1, 4'h9, 0);
    step(1,1,1,1, 4'h0, 0);
    check(rv0 == 1 && rk0 == 2'd0 && rrow0 == 4'd9, "R7", "ras-only report",
          {rv0, rk0, rrow0}, {1'b1, 2'd0, 4'd9});
    step(1,1,1,1, 4'h0, 0);

    // R8 CAS-before-RAS, counter untouched by R7 cycle
    step(1,0,1,1, 4'h0, 0);
    step(0,0,1,1, 4'h0, 0);
    check(rv0 == 1 && rk0 == 2'd1 && rrow0 == 4'd1, "R8", "cbr report",
          {rv0, rk0, rrow0}, {1'b1, 2'd1, 4'd1});
    step(1,0,1,1, 4'h0, 0);
    step(1,1,1,1, 4'h0, 0);
    check(err0 == 0, "R10", "no error yet", err0, 0);

    // R1 again, then R8 wrap with R10 kept quiet
    do_reset();
    @(negedge clk);
    check(rv0 == 0 && oe0 == 0 && err0 == 0, "R1", "second reset", {rv0, oe0, err0}, 0);
    exp_cnt = 0;
    for (int i = 0; i < 60; i++) begin
      step(1,0,1,1, 4'h0, 0);
      step(0,0,1,1, 4'h0, 0);
      check(rv1 == 1 && rk1 == 2'd1 && rrow1 == 4'(exp_cnt), "R8", "cbr counter",
            {rv1, rk1, rrow1}, {1'b1, 2'd1, 4'(exp_cnt)});
      exp_cnt = (exp_cnt + 1) % 16;
      step(1,0,1,1, 4'h0, 0);
      step(1,1,1,1, 4'h0, 0);
    end
    check(err0 == 0 && err1 == 0, "R10", "kept refreshed", {err0, err1}, 0);
    repeat (220) step(1,1,1,1, 4'h0, 0);
    check(err0 == 1, "R10", "stale row error", err0, 1);
    step(0,1,1,1, 4'h2, 0);
    step(1,1,1,1, 4'h0, 0);
    check(err0 == 1, "R10", "error sticky", err0, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule